// File: doc/BRIEF.md
# Timer Tick Prescaler with Even-Ratio Divider

This block derives a slow tick for a pair of general-purpose timers from the fast system oscillator clock. It does not make a new clock. It produces a clock-enable pulse that is one cycle wide and that repeats at the divided rate, so every downstream timer register stays in the oscillator domain. The division ratio is read from a 6-bit field that sits at bits 21:16 of a 32-bit system configuration word. The rest of that word is not decoded here.

The encoding of the field is irregular. Any odd code means no division, so a tick occurs on every cycle. Code zero divides by two. An even code from 2 to 62 divides by that code. A new ratio is adopted only when the running period ends, so a reprogramming never produces a shortened tick interval.

Each timer has its own gate bit. When a timer's gate bit is cleared, that timer's tick is suppressed, which lets software idle the timer and save power. The shared base tick keeps running regardless of the gates.

Top module: `tmr_tick_prescaler`

## Requirements
- R1: The ratio code is taken only from `sys_cfg[21:16]`. The other bits of `sys_cfg` have no effect on the tick rate.
- R2: Any odd code selects a ratio of 1, so `base_tick` is high on every cycle.
- R3: Code 0 selects a ratio of 2, so `base_tick` pulses once every 2 cycles.
- R4: An even code N from 2 to 62 selects a ratio of N, so `base_tick` rising edges are N cycles apart.
- R5: At a ratio above 1, each `base_tick` pulse is exactly one cycle wide, and N-1 idle cycles follow it.
- R6: A code change takes effect only at the end of the current period. The interval in flight completes at the old ratio, and the next interval uses the new ratio.
- R7: `tmr_tick[i]` never pulses while `tmr_gate[i]` is 0. While `tmr_gate[i]` is 1, `tmr_tick[i]` pulses once per base tick.
- R8: While `rst` is high, both `base_tick` and `tmr_tick` are 0. After `rst` is released with ratio R loaded, the first `base_tick` appears R cycles later.
- R9: A `tmr_tick` bit is high only in a cycle in which `base_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_cfg | input | 32 | System configuration word; the ratio code is at bits 21:16 |
| tmr_gate | input | 2 | Per-timer gate bits; 1 lets that timer's tick through |
| base_tick | output | 1 | Ungated divided clock-enable pulse, registered |
| tmr_tick | output | 2 | Per-timer gated clock-enable pulses, registered |

## Verification
The scoreboard measures the number of cycles between successive base ticks and compares each measurement with a ratio computed from the code.

The bench drives several odd codes, including 1, 17 and 63. A decoder that divided by an odd code would show intervals of 17 or 63 instead of 1. Code 0 is driven with all of the unrelated configuration bits set. A decoder that took its field from the wrong bits, or that treated zero as a stop or a divide-by-one, would give an interval other than 2.

The most important case is a reprogramming from ratio 62 down to 4, made ten cycles into a period. A design that switched immediately would cut that interval short, where a correct one still delivers 62 cycles before changing.

Gate windows with each gate pattern show whether a cleared gate still leaks ticks or whether a set gate drops them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Default geometry of the configuration word and the divider field.
  localparam int unsigned CFG_W_DEF     = 32;
  localparam int unsigned FIELD_LSB_DEF = 16;
  localparam int unsigned FIELD_W_DEF   = 6;
  localparam int unsigned NUM_TMR_DEF   = 2;

  // Legal active ratio: 1, or any nonzero even value.
  function automatic logic ratio_legal(input logic [7:0] r);
    return (r == 8'd1) || ((r != 8'd0) && !r[0]);
  endfunction
endpackage

// File: rtl/tmr_ratio_decode.sv
module tmr_ratio_decode #(
  parameter int unsigned FIELD_W = tmr_pkg::FIELD_W_DEF
) (
  input  logic [FIELD_W-1:0] code,
  output logic [FIELD_W-1:0] ratio
);
  localparam logic [FIELD_W-1:0] RATIO_ONE  = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] RATIO_ZERO = FIELD_W'(2);

  // Odd codes collapse to 1, zero becomes 2, even codes pass through.
  always_comb begin
    if (code[0])             ratio = RATIO_ONE;
    else if (code == '0)     ratio = RATIO_ZERO;
    else                     ratio = code;
  end
endmodule

// File: rtl/tmr_tick_counter.sv
module tmr_tick_counter #(
  parameter int unsigned FIELD_W = tmr_pkg::FIELD_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] next_ratio,
  output logic               term,
  output logic               tick_q
);
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] ratio_q;

  // End of the running period.
  assign term = (cnt_q == (ratio_q - FIELD_W'(1)));

  // The ratio is reloaded only at the end of a period, so a reprogramming
  // never shortens the interval that is already running.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= next_ratio;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= term;
      if (term) begin
        cnt_q   <= '0;
        ratio_q <= next_ratio;
      end else begin
        cnt_q   <= cnt_q + FIELD_W'(1);
      end
    end
  end

  // R5: above ratio 1 a pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (tick_q && ratio_q != FIELD_W'(1)) |=> !tick_q);

  // R6: the active ratio holds between terminal counts
  a_r6_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(ratio_q));

  // R4: the active ratio is always 1 or a nonzero even value
  a_r4_ratio_legal: assert property (@(posedge clk) disable iff (rst)
    tmr_pkg::ratio_legal(8'(ratio_q)));

  // R8: reset clears the base tick
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> !tick_q);
endmodule

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
  parameter int unsigned NUM_TMR = tmr_pkg::NUM_TMR_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               term,
  input  logic               base_tick,
  input  logic [NUM_TMR-1:0] gate,
  output logic [NUM_TMR-1:0] tick_o
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (rst) tick_o[i] <= 1'b0;
      else     tick_o[i] <= term & gate[i];
    end

    // R7: a closed gate lets no tick through
    a_r7_gate_closed: assert property (@(posedge clk) disable iff (rst)
      !gate[i] |=> !tick_o[i]);

    // R9: a timer tick only coincides with a base tick
    a_r9_subset: assert property (@(posedge clk) disable iff (rst)
      tick_o[i] |-> base_tick);
  end
endmodule

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler #(
  parameter int unsigned CFG_W     = tmr_pkg::CFG_W_DEF,
  parameter int unsigned FIELD_LSB = tmr_pkg::FIELD_LSB_DEF,
  parameter int unsigned FIELD_W   = tmr_pkg::FIELD_W_DEF,
  parameter int unsigned NUM_TMR   = tmr_pkg::NUM_TMR_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   sys_cfg,
  input  logic [NUM_TMR-1:0] tmr_gate,
  output logic               base_tick,
  output logic [NUM_TMR-1:0] tmr_tick
);
  localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  logic [FIELD_W-1:0] code;
  logic [FIELD_W-1:0] ratio;
  logic               term;
  logic               unused_cfg_bits;

  assign code            = sys_cfg[FIELD_MSB:FIELD_LSB];
  assign unused_cfg_bits = ^{sys_cfg[CFG_W-1:FIELD_MSB+1], sys_cfg[FIELD_LSB-1:0]};

  tmr_ratio_decode #(.FIELD_W(FIELD_W)) u_decode (
    .code  (code),
    .ratio (ratio)
  );

  tmr_tick_counter #(.FIELD_W(FIELD_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .next_ratio (ratio),
    .term       (term),
    .tick_q     (base_tick)
  );

  tmr_tick_gate #(.NUM_TMR(NUM_TMR)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .term      (term),
    .base_tick (base_tick),
    .gate      (tmr_gate),
    .tick_o    (tmr_tick)
  );
endmodule

// File: tb/tmr_tick_prescaler_tb.sv
module tmr_tick_prescaler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sys_cfg = 32'h0;
  logic [1:0]  tmr_gate = 2'b11;
  logic        base_tick;
  logic [1:0]  tmr_tick;

  int checks = 0;
  int fails  = 0;

  int    exp_q[$];
  string tag_q[$];

  int base_cnt = 0;
  int tmr_cnt[2];
  int stray = 0;
  logic [31:0] cur_cfg = 32'h0;

  always #10 clk = ~clk;

  tmr_tick_prescaler u_dut (
    .clk(clk), .rst(rst), .sys_cfg(sys_cfg), .tmr_gate(tmr_gate),
    .base_tick(base_tick), .tmr_tick(tmr_tick)
  );

  // Ratio model written from R2, R3, R4 (field at bits 21:16 per R1).
  function automatic int model_ratio(input logic [31:0] cfg);
    logic [5:0] c;
    c = cfg[21:16];
    if (c[0]) return 1;
    if (c == 6'd0) return 2;
    return int'(c);
  endfunction

  task automatic check(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Monitor: measures tick intervals and pops the scoreboard.
  initial begin
    int cyc = 0;
    int last = 0;
    bit have_last = 0;
    tmr_cnt[0] = 0;
    tmr_cnt[1] = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        cyc++;
        for (int i = 0; i < 2; i++) begin
          if (tmr_tick[i]) tmr_cnt[i]++;
          if (tmr_tick[i] && !base_tick) stray++;
        end
        if (base_tick) begin
          base_cnt++;
          if (have_last && exp_q.size() > 0)
            check(tag_q.pop_front(), cyc - last, exp_q.pop_front(), "tick interval");
          last = cyc;
          have_last = 1;
        end
      end
    end
  end

  task automatic sync_tick();
    do @(negedge clk); while (!base_tick);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    #1;
  endtask

  // Driver: change the code right after a tick; the in-flight period keeps the old ratio (R6).
  task automatic apply(input logic [31:0] cfg, input int n, input string tag);
    sync_tick();
    exp_q.push_back(model_ratio(cur_cfg)); tag_q.push_back("R6");
    cur_cfg = cfg;
    sys_cfg = cfg;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model_ratio(cfg)); tag_q.push_back(tag);
    end
    drain();
  endtask

  // Change the code part way through a period (R6).
  task automatic apply_mid(input logic [31:0] cfg, input int delay);
    sync_tick();
    exp_q.push_back(model_ratio(cur_cfg)); tag_q.push_back("R6");
    repeat (delay) @(negedge clk);
    #1;
    cur_cfg = cfg;
    sys_cfg = cfg;
    exp_q.push_back(model_ratio(cfg)); tag_q.push_back("R6");
    exp_q.push_back(model_ratio(cfg)); tag_q.push_back("R4");
    drain();
  endtask

  // Gate window: count per-timer ticks over n base ticks (R7).
  task automatic gate_window(input logic [1:0] g, input int n);
    int snap;
    sync_tick();
    tmr_gate = g;
    base_cnt = 0;
    tmr_cnt[0] = 0;
    tmr_cnt[1] = 0;
    while (base_cnt < n) @(negedge clk);
    #1;
    snap = base_cnt;
    for (int i = 0; i < 2; i++)
      check("R7", tmr_cnt[i], g[i] ? snap : 0, $sformatf("timer %0d tick count", i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", int'(base_tick), 0, "base_tick in reset");
    check("R8", int'(tmr_tick), 0, "tmr_tick in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R8", int'(base_tick), 0, "first cycle after reset");
    @(negedge clk);
    check("R8", int'(base_tick), 1, "first tick at ratio 2");

    // R1 and R3: code 0 with every unrelated bit set
    apply(32'hFFC0_FFFF, 3, "R1");
    apply(32'h0000_0000, 3, "R3");
    apply(32'h0004_0000, 3, "R4 R5");
    apply(32'h0001_0000, 4, "R2");
    apply(32'h003E_0000, 2, "R4 R5");
    apply(32'h003F_0000, 4, "R2");
    apply(32'h0011_0000, 3, "R2");
    apply(32'h0002_0000, 3, "R4 R5");
    apply(32'h000A_0000, 3, "R4 R5");
    apply(32'h003E_0000, 1, "R4");
    apply_mid(32'h0004_0000, 10);

    gate_window(2'b01, 6);
    gate_window(2'b10, 6);
    gate_window(2'b00, 6);
    gate_window(2'b11, 6);

    check("R9", stray, 0, "timer ticks outside base tick");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule